// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is an I2C target that sits in front of an 8 KiB on-chip memory. The memory is held in registers as 1024 rows of 64 bits. A bus master selects the block with a device-select byte. That byte carries a fixed type code and three bits that must equal the `strap_i` pins, so up to eight of these blocks can share one bus. The master then sends a two-byte word address and either writes data bytes or issues a read.

Each write byte goes into the array in the same cycle that its eighth bit has been taken in. There is no busy period, and the next command is accepted at once. Reads return one byte per ninth-clock acknowledge from the master. An address latch holds its value between transactions, so a read can pick up where the last access stopped.

A write-protect input shields the top quarter of the array. SCL and SDA are oversampled by the system clock. SDA is driven only as an open-drain pull-down enable.

Top module: `i2c_mem_target`

## Requirements
- R1: The device-select byte is decoded MSB first. Bits 7..4 must be 4'b1010 and bits 3..1 must equal `strap_i[2:0]`. Bit 0 selects the direction (1 = read, 0 = write). On a match the block pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next START or STOP.
- R2: After a write-select, the next two bytes form the word address. The address is {first[4:0], second}, and bits 7..5 of the first byte are ignored. Both bytes are acknowledged.
- R3: Every data byte after the address is stored at the latched address and acknowledged. A new transaction right after STOP is acknowledged without any busy delay.
- R4: The address latch advances by one after each byte written or read, and it wraps from 0x1FFF to 0x0000.
- R5: A read-select that follows a STOP starts reading at the latched address, which is the address after the last byte accessed.
- R6: On a read, the block shifts out 8 bits MSB first and then samples the master's ninth bit. A low (ACK) gives the next sequential byte. A high (NACK) makes the block release SDA and stay off the bus until START or STOP.
- R7: With `wp_i` high, bytes aimed at 0x1800..0x1FFF are acknowledged and still advance the latch, but the array keeps its old contents.
- R8: With `wp_i` low, every address, including 0x1800..0x1FFF, is writable.
- R9: A START or STOP seen part-way through a byte aborts the byte and releases SDA. A START begins a new device-select byte.
- R10: SDA is only ever pulled low through `sda_oe_o`. The pull-down may start only after a SCL falling edge and never changes while SCL is high.
- R11: Reset releases SDA and clears the address latch to 0x0000. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 3 | Board-set bus address bits |
| wp_i | input | 1 | High protects the top quarter of the array; tie low when unused |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench sets the upper bits of the address byte, which a design must ignore; a design that kept them would write to the wrong location. It runs a two-byte write across 0x1FFF and reads it back, so a latch that does not wrap would lose the second byte. It writes with protection across the 0x17FF/0x1800 boundary, where a design that skipped the latch increment on a blocked byte would return the wrong byte on the next current-address read. It also aborts bytes with a START and with a STOP, clocks the bus after a master NACK and after a device-select mismatch, and resets with the latch non-zero. Each of these catches a block that keeps driving the bus or writes a half-received byte.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_DATA
  } kind_e;

  function automatic kind_e next_kind(kind_e k);
    unique case (k)
      K_DEV:   return K_AHI;
      K_AHI:   return K_ALO;
      default: return K_DATA;
    endcase
  endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[LEN-2:0], scl_i};
      sda_q <= {sda_q[LEN-2:0], sda_i};
    end
  end

  logic scl_c, scl_p, sda_c, sda_p;
  assign scl_c = scl_q[STAGES-1];
  assign scl_p = scl_q[STAGES];
  assign sda_c = sda_q[STAGES-1];
  assign sda_p = sda_q[STAGES];

  assign sda_o      = sda_c;
  assign scl_rise_o = scl_c & ~scl_p;
  assign scl_fall_o = ~scl_c & scl_p;
  // data edges while clock is high frame a transfer
  assign start_o    = scl_c & scl_p & sda_p & ~sda_c;
  assign stop_o     = scl_c & scl_p & ~sda_p & sda_c;

endmodule

// File: rtl/i2c_mem_rows.sv
module i2c_mem_rows #(
  parameter int ROWS   = 1024,
  parameter int ROW_W  = 64,
  parameter int ADDR_W = $clog2(ROWS) + $clog2(ROW_W / 8)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int BPR   = ROW_W / 8;
  localparam int COL_W = $clog2(BPR);

  logic [ROW_W-1:0] rows_q [ROWS];
  logic [ADDR_W-COL_W-1:0] row;
  logic [COL_W-1:0]        col;
  logic [ROW_W-1:0]        row_data;
  logic [7:0]              lane [BPR];

  assign row      = addr_i[ADDR_W-1:COL_W];
  assign col      = addr_i[COL_W-1:0];
  assign row_data = rows_q[row];

  always_ff @(posedge clk_i) begin
    if (we_i) rows_q[row][{col, 3'b000} +: 8] <= wdata_i;
  end

  for (genvar l = 0; l < BPR; l++) begin : g_lane
    assign lane[l] = row_data[l*8 +: 8];
  end

  assign rdata_o = lane[col];

endmodule

// File: rtl/i2c_mem_engine.sv
module i2c_mem_engine
  import i2c_mem_pkg::*;
#(
  parameter int          ADDR_W   = 13,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              sda_oe_o
);
  localparam int HI_W = ADDR_W - 8;

  phase_e            ph_q;
  kind_e             kind_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic [HI_W-1:0]   ahi_q;
  logic [ADDR_W-1:0] lat_q;
  logic              rd_q, mack_q, oe_q;

  logic dev_hit, prot, byte_end;

  assign dev_hit  = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:1] == strap_i);
  assign prot     = wp_i && (lat_q[ADDR_W-1 -: 2] == 2'b11);
  assign byte_end = (ph_q == PH_RX) && scl_fall_i && (cnt_q == 4'd8);

  assign mem_we_o    = byte_end && (kind_q == K_DATA) && !prot;
  assign mem_addr_o  = lat_q;
  assign mem_wdata_o = sh_q;
  assign sda_oe_o    = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      kind_q <= K_DEV;
      cnt_q  <= '0;
      sh_q   <= '0;
      ahi_q  <= '0;
      lat_q  <= '0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_i) begin
      ph_q   <= PH_RX;
      kind_q <= K_DEV;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
    end else if (stop_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_RX: begin
          if (scl_rise_i && cnt_q != 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_end) begin
            cnt_q <= '0;
            unique case (kind_q)
              K_DEV: begin
                if (dev_hit) begin
                  rd_q <= sh_q[0];
                  oe_q <= 1'b1;
                  ph_q <= PH_ACK;
                end else begin
                  ph_q <= PH_IDLE;
                end
              end
              K_AHI: begin
                ahi_q <= sh_q[HI_W-1:0];
                oe_q  <= 1'b1;
                ph_q  <= PH_ACK;
              end
              K_ALO: begin
                lat_q <= {ahi_q, sh_q};
                oe_q  <= 1'b1;
                ph_q  <= PH_ACK;
              end
              default: begin
                // protected bytes are acked and still advance the latch
                lat_q <= lat_q + 1'b1;
                oe_q  <= 1'b1;
                ph_q  <= PH_ACK;
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall_i) begin
            if (kind_q == K_DEV && rd_q) begin
              ph_q  <= PH_TX;
              sh_q  <= mem_rdata_i;
              oe_q  <= ~mem_rdata_i[7];
              lat_q <= lat_q + 1'b1;
              cnt_q <= 4'd1;
            end else begin
              ph_q   <= PH_RX;
              kind_q <= next_kind(kind_q);
              oe_q   <= 1'b0;
              cnt_q  <= '0;
            end
          end
        end
        PH_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == 4'd8) begin
              oe_q <= 1'b0;
              ph_q <= PH_MACK;
            end else begin
              sh_q  <= {sh_q[6:0], 1'b0};
              oe_q  <= ~sh_q[6];
              cnt_q <= cnt_q + 4'd1;
            end
          end
        end
        PH_MACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              ph_q  <= PH_TX;
              sh_q  <= mem_rdata_i;
              oe_q  <= ~mem_rdata_i[7];
              lat_q <= lat_q + 1'b1;
              cnt_q <= 4'd1;
            end else begin
              ph_q <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int         ROWS        = 1024,
  parameter int         ROW_W       = 64,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int ADDR_W = $clog2(ROWS) + $clog2(ROW_W / 8);

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;

  i2c_bus_sampler #(
    .STAGES(SYNC_STAGES)
  ) i_sampler (
    .clk_i,
    .rst_ni,
    .scl_i,
    .sda_i,
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_mem_engine #(
    .ADDR_W  (ADDR_W),
    .DEV_TYPE(DEV_TYPE)
  ) i_engine (
    .clk_i,
    .rst_ni,
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .strap_i,
    .wp_i,
    .mem_rdata_i(mem_rdata),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .mem_wdata_o(mem_wdata),
    .sda_oe_o
  );

  i2c_mem_rows #(
    .ROWS  (ROWS),
    .ROW_W (ROW_W),
    .ADDR_W(ADDR_W)
  ) i_rows (
    .clk_i,
    .we_i   (mem_we),
    .addr_i (mem_addr),
    .wdata_i(mem_wdata),
    .rdata_o(mem_rdata)
  );

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe_o,
  input logic              wp_i,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  a_r10_drive_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  a_r7_protect_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> !(wp_i && mem_addr[ADDR_W-1 -: 2] == 2'b11));

  a_r4_latch_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  a_r9_start_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);

  a_r9_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r11_reset_release: assert (!sda_oe_o);
    end
  end

endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_fall (scl_fall),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe_o (sda_oe_o),
  .wp_i     (wp_i),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;
  localparam int         Q     = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_bus;

  int checks = 0;
  int fails = 0;
  int viol = 0;
  bit done = 1'b0;

  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #10 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_mem_target i_i2c_mem_target (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_bus),
    .strap_i (STRAP),
    .wp_i    (wp),
    .sda_oe_o(sda_oe)
  );

  // R10 monitor: pull-down must not move while SCL is high
  logic prev_oe = 1'b0;
  always @(posedge clk) begin
    if (rst_n && scl && (sda_oe != prev_oe)) viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      tick(Q); m_sda = b[7-i];
      tick(Q); scl = 1'b1;
      tick(2*Q); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    tick(Q); m_sda = 1'b1;
    tick(Q); scl = 1'b1;
    tick(Q); ack = ~sda_bus;
    tick(Q); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(2*Q); scl = 1'b1;
      tick(Q); d[7-i] = sda_bus;
      tick(Q); scl = 1'b0;
    end
    tick(Q); m_sda = ~give_ack;
    tick(Q); scl = 1'b1;
    tick(2*Q); scl = 1'b0;
  endtask

  task automatic write_seq(input logic [7:0] hi, input logic [7:0] lo, input int n, input string req);
    logic a;
    bus_start();
    send_byte(DEV_W, a); chk(a, req, 16'(a), 16'd1);
    send_byte(hi, a);    chk(a, req, 16'(a), 16'd1);
    send_byte(lo, a);    chk(a, req, 16'(a), 16'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); chk(a, req, 16'(a), 16'd1);
    end
    bus_stop();
  endtask

  task automatic read_tail(input int n);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic read_at(input logic [7:0] hi, input logic [7:0] lo, input int n, input string req);
    logic a;
    bus_start();
    send_byte(DEV_W, a); chk(a, req, 16'(a), 16'd1);
    send_byte(hi, a);    chk(a, req, 16'(a), 16'd1);
    send_byte(lo, a);    chk(a, req, 16'(a), 16'd1);
    bus_start();
    send_byte(DEV_R, a); chk(a, req, 16'(a), 16'd1);
    read_tail(n);
  endtask

  task automatic read_cur(input int n, input string req);
    logic a;
    bus_start();
    send_byte(DEV_R, a); chk(a, req, 16'(a), 16'd1);
    read_tail(n);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R11 SDA released after reset", 16'(sda_oe), 16'd0);
  endtask

  task automatic t_write_read();
    // address byte 0xE1: bits 7..5 must be ignored -> 0x0123
    wbuf[0] = 8'h10; wbuf[1] = 8'h21; wbuf[2] = 8'h32; wbuf[3] = 8'h43; wbuf[4] = 8'h54;
    write_seq(8'hE1, 8'h23, 5, "R2 R3 write acks");
    read_at(8'h01, 8'h23, 4, "R3 R6 read acks");
    for (int i = 0; i < 4; i++)
      chk(rbuf[i] == wbuf[i], "R2 R6 sequential read data", 16'(rbuf[i]), 16'(wbuf[i]));
    read_cur(1, "R5 current read ack");
    chk(rbuf[0] == 8'h54, "R5 current address read", 16'(rbuf[0]), 16'h54);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte({4'b1010, STRAP ^ 3'b001, 1'b0}, a);
    chk(!a, "R1 strap mismatch NACK", 16'(a), 16'd0);
    send_byte(8'h00, a);
    chk(!a, "R1 ignored after mismatch", 16'(a), 16'd0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, a);
    chk(!a, "R1 type code mismatch NACK", 16'(a), 16'd0);
    bus_stop();
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
    write_seq(8'h1F, 8'hFF, 2, "R8 top quarter write acks");
    read_at(8'h1F, 8'hFF, 2, "R4 wrap read acks");
    chk(rbuf[0] == 8'hC1, "R8 write at 0x1FFF with wp low", 16'(rbuf[0]), 16'hC1);
    chk(rbuf[1] == 8'hC2, "R4 latch wraps to 0x0000", 16'(rbuf[1]), 16'hC2);
  endtask

  task automatic t_reset_latch();
    // latch is 0x0001 here; reset must bring it to 0x0000
    rst_n = 1'b0; tick(4);
    chk(sda_oe == 1'b0, "R11 SDA released in reset", 16'(sda_oe), 16'd0);
    rst_n = 1'b1; tick(4);
    read_cur(1, "R11 read after reset ack");
    chk(rbuf[0] == 8'hC2, "R11 latch cleared by reset", 16'(rbuf[0]), 16'hC2);
  endtask

  task automatic t_protect();
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
    write_seq(8'h17, 8'hFF, 4, "R8 prefill acks");
    wp = 1'b1;
    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; wbuf[2] = 8'h7C;
    write_seq(8'h17, 8'hFF, 3, "R7 protected bytes still acked");
    read_cur(1, "R7 current read ack");
    chk(rbuf[0] == 8'h04, "R7 latch advanced past blocked bytes", 16'(rbuf[0]), 16'h04);
    read_at(8'h17, 8'hFF, 3, "R7 read acks");
    chk(rbuf[0] == 8'h5A, "R7 unprotected byte written", 16'(rbuf[0]), 16'h5A);
    chk(rbuf[1] == 8'h02, "R7 0x1800 unchanged", 16'(rbuf[1]), 16'h02);
    chk(rbuf[2] == 8'h03, "R7 0x1801 unchanged", 16'(rbuf[2]), 16'h03);
    wp = 1'b0;
  endtask

  task automatic t_nack_release();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(DEV_W, a); chk(a, "R6 setup ack", 16'(a), 16'd1);
    send_byte(8'h01, a);
    send_byte(8'h23, a);
    bus_start();
    send_byte(DEV_R, a); chk(a, "R6 read select ack", 16'(a), 16'd1);
    recv_byte(1'b0, d);
    chk(d == 8'h10, "R6 byte before NACK", 16'(d), 16'h10);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R6 bus released after NACK", 16'(d), 16'hFF);
    bus_stop();
  endtask

  task automatic t_abort();
    logic a;
    wbuf[0] = 8'h11; wbuf[1] = 8'h33;
    write_seq(8'h00, 8'h40, 2, "R9 prefill acks");
    bus_start();
    send_bits(DEV_W, 4);
    bus_start();
    send_byte(DEV_W, a); chk(a, "R9 select after mid-byte START", 16'(a), 16'd1);
    send_byte(8'h00, a);
    send_byte(8'h40, a);
    send_byte(8'h99, a); chk(a, "R9 data ack", 16'(a), 16'd1);
    send_bits(8'h55, 4);
    bus_stop();
    read_at(8'h00, 8'h40, 2, "R9 readback acks");
    chk(rbuf[0] == 8'h99, "R9 full byte written", 16'(rbuf[0]), 16'h99);
    chk(rbuf[1] == 8'h33, "R9 partial byte discarded", 16'(rbuf[1]), 16'h33);
  endtask

  initial begin
    tick(5);
    t_reset();
    rst_n = 1'b1;
    tick(5);
    t_write_read();
    t_mismatch();
    t_wrap();
    t_reset_latch();
    t_protect();
    t_nack_release();
    t_abort();
    chk(viol == 0, "R10 SDA stable while SCL high", 16'(viol), 16'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule